// File: doc/BRIEF.md
# Packed Saturating Shift-Add Unit

This block is a SIMD datapath stage for a processor execution cluster. It takes two 64-bit source words, each holding four signed 16-bit lanes. In every lane it shifts the element of the first source left by a common count of 1 to 3 bit positions, with zeros entering at the bottom. It then adds the element of the second source. Each lane saturates to the signed 16-bit range in two steps. If the shift alone leaves the 16-bit range, that clamped value is the lane result and the add is skipped. Otherwise the sum is clamped.

Each source carries a deferred-exception tag bit, and the result tag is the OR of the two. A qualifying predicate gates the write. When the predicate is false, nothing is written and the held result stays as it was. A count of zero is not a legal encoding. With a true predicate it raises an illegal-operation flag instead of writing. The result, its tag, the write valid and the flag are all registered, so they appear one cycle after the request.

A small control state machine classifies each cycle's request and holds the outcome of the previous cycle. Its states are:

| State | Meaning |
|---|---|
| ST_IDLE | No request was presented. |
| ST_WRITE | A request was written. |
| ST_SKIP | A request was suppressed by its predicate. |
| ST_FAULT | A request had an illegal count. |

On every clock edge the machine enters the state that matches the request seen in that cycle, and it can move from any state to any other. The transitions are named after the request that causes them:

| Transition | Condition |
|---|---|
| go_idle | Valid is low. |
| go_skip | Valid is high and the predicate is low. |
| go_fault | Valid and predicate are high and the count is 0. |
| go_write | Valid and predicate are high and the count is 1 to 3. |

Top module: `psa_unit`

## Requirements
- R1: Lane i occupies bits [16i+15:16i] of `src_a`, `src_b` and `res_data`, for i from 0 to 3. Each lane's result depends only on that lane's elements and the shared count.
- R2: When a lane does not saturate, its result is (a << count) + b in two's complement, with zeros filling the vacated low bits.
- R3: If a << count exceeds +32767, the lane result is 0x7FFF whatever b is, because the add is skipped.
- R4: If a << count is below −32768, the lane result is 0x8000 whatever b is, because the add is skipped.
- R5: If the shift stays in range and the sum exceeds +32767, the lane result is 0x7FFF. If the sum is below −32768, the lane result is 0x8000.
- R6: On a write, `res_tag` equals `tag_a` OR `tag_b`.
- R7: When `req_valid`=1 and `pred`=0, the next cycle shows `res_valid`=0 and `bad_count`=0. `res_data` and `res_tag` keep their previous values.
- R8: When `req_valid`=1, `pred`=1 and `shamt`=2'b00, the next cycle shows `bad_count`=1 and `res_valid`=0. `res_data` and `res_tag` are unchanged.
- R9: A legal request (valid, predicate true, count 1 to 3) produces `res_valid`=1 together with its result exactly one clock later. `res_valid` and `bad_count` are never high together.
- R10: After reset, `res_data`=0, `res_tag`=0, `res_valid`=0 and `bad_count`=0.
- R11: A cycle with `req_valid`=0 leaves `res_data` and `res_tag` unchanged. The next cycle shows `res_valid`=0 and `bad_count`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| pred | input | 1 | Qualifying predicate; 0 suppresses the write |
| shamt | input | 2 | Common left-shift count; 0 is illegal |
| src_a | input | 64 | Four packed elements to be shifted |
| src_b | input | 64 | Four packed addends |
| tag_a | input | 1 | Deferred-exception tag of `src_a` |
| tag_b | input | 1 | Deferred-exception tag of `src_b` |
| res_data | output | 64 | Registered packed result |
| res_tag | output | 1 | Registered result tag |
| res_valid | output | 1 | Result written in the previous cycle |
| bad_count | output | 1 | Previous request had an illegal count |

## Verification
The bench builds the block with its defaults: four lanes of 16 bits, a 2-bit count and a 20-bit internal width. With these defaults the largest count, 3, can push a lane past either 16-bit limit on its own. The vectors mix shift-saturated, add-saturated and unsaturated lanes within the same word. Some vectors sit exactly on the limits, for example −4096 shifted by 3 reaching −32768 without clamping, so that the shift-stage clamp and the add-stage clamp can each be told apart.

// File: rtl/psa_pkg.sv
package psa_pkg;

    // Default geometry of the packed operand.
    localparam int LANE_W_DEF = 16;
    localparam int LANES_DEF  = 4;
    localparam int CNT_W_DEF  = 2;

    // Outcome of the request seen in the previous cycle.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_SKIP  = 2'd2,
        ST_FAULT = 2'd3
    } psa_state_t;

endpackage

// File: rtl/psa_lane.sv
module psa_lane #(
    parameter int LANE_W = 16,
    parameter int CNT_W  = 2
) (
    input  logic [LANE_W-1:0] elem_a,
    input  logic [LANE_W-1:0] elem_b,
    input  logic [CNT_W-1:0]  cnt,
    output logic [LANE_W-1:0] elem_res
);
    localparam int MAX_SH = (1 << CNT_W) - 1;
    localparam int EXT_W  = LANE_W + MAX_SH + 1;
    localparam int PAD_W  = EXT_W - LANE_W;

    logic signed [EXT_W-1:0] a_ext;
    logic signed [EXT_W-1:0] b_ext;
    logic signed [EXT_W-1:0] shifted;
    logic signed [EXT_W-1:0] sum;
    logic signed [EXT_W-1:0] lim_hi;
    logic signed [EXT_W-1:0] lim_lo;
    logic                    sh_over;
    logic [LANE_W-1:0]       sh_clamped;
    logic [LANE_W-1:0]       sum_clamped;

    always_comb begin
        a_ext   = {{PAD_W{elem_a[LANE_W-1]}}, elem_a};
        b_ext   = {{PAD_W{elem_b[LANE_W-1]}}, elem_b};
        lim_hi  = {{(PAD_W+1){1'b0}}, {(LANE_W-1){1'b1}}};
        lim_lo  = ~lim_hi;
        shifted = a_ext <<< cnt;
        sum     = shifted + b_ext;
    end

    // First stage: clamp the shifted value.
    always_comb begin
        sh_over = 1'b1;
        if (shifted > lim_hi) begin
            sh_clamped = lim_hi[LANE_W-1:0];
        end else if (shifted < lim_lo) begin
            sh_clamped = lim_lo[LANE_W-1:0];
        end else begin
            sh_clamped = shifted[LANE_W-1:0];
            sh_over    = 1'b0;
        end
    end

    // Second stage: clamp the sum.
    always_comb begin
        if (sum > lim_hi) begin
            sum_clamped = lim_hi[LANE_W-1:0];
        end else if (sum < lim_lo) begin
            sum_clamped = lim_lo[LANE_W-1:0];
        end else begin
            sum_clamped = sum[LANE_W-1:0];
        end
    end

    // A saturated shift overrides the add.
    assign elem_res = sh_over ? sh_clamped : sum_clamped;

endmodule

// File: rtl/psa_ctrl.sv
module psa_ctrl
    import psa_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             pred,
    input  logic [CNT_W-1:0] shamt,
    output logic             wr_en,
    output logic             res_valid,
    output logic             bad_count
);
    psa_state_t state_q;
    psa_state_t state_d;

    // Next state: classify the incoming request.
    always_comb begin
        if (!req_valid) begin
            state_d = ST_IDLE;   // go_idle
        end else if (!pred) begin
            state_d = ST_SKIP;   // go_skip
        end else if (shamt == '0) begin
            state_d = ST_FAULT;  // go_fault
        end else begin
            state_d = ST_WRITE;  // go_write
        end
        wr_en = (state_d == ST_WRITE);
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs.
    always_comb begin
        res_valid = 1'b0;
        bad_count = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_WRITE: res_valid = 1'b1;
            ST_SKIP:  ;
            ST_FAULT: bad_count = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/psa_unit.sv
module psa_unit
    import psa_pkg::*;
#(
    parameter int LANES  = LANES_DEF,
    parameter int LANE_W = LANE_W_DEF,
    parameter int CNT_W  = CNT_W_DEF,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              pred,
    input  logic [CNT_W-1:0]  shamt,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic              tag_a,
    input  logic              tag_b,
    output logic [DATA_W-1:0] res_data,
    output logic              res_tag,
    output logic              res_valid,
    output logic              bad_count
);
    logic [DATA_W-1:0] lane_res;
    logic              wr_en;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        psa_lane #(
            .LANE_W (LANE_W),
            .CNT_W  (CNT_W)
        ) lane_i (
            .elem_a   (src_a[g*LANE_W +: LANE_W]),
            .elem_b   (src_b[g*LANE_W +: LANE_W]),
            .cnt      (shamt),
            .elem_res (lane_res[g*LANE_W +: LANE_W])
        );
    end

    psa_ctrl #(
        .CNT_W (CNT_W)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .pred      (pred),
        .shamt     (shamt),
        .wr_en     (wr_en),
        .res_valid (res_valid),
        .bad_count (bad_count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_data <= '0;
            res_tag  <= 1'b0;
        end else if (wr_en) begin
            res_data <= lane_res;
            res_tag  <= tag_a | tag_b;
        end
    end

endmodule

// File: rtl/psa_unit_chk.sv
module psa_unit_chk #(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              pred,
    input logic [CNT_W-1:0]  shamt,
    input logic              tag_a,
    input logic              tag_b,
    input logic [DATA_W-1:0] res_data,
    input logic              res_tag,
    input logic              res_valid,
    input logic              bad_count
);
    // R9
    excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && bad_count));

    // R9
    write_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pred && shamt != '0) |=> res_valid);

    // R6
    tag_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pred && shamt != '0) |=> (res_tag == ($past(tag_a) | $past(tag_b))));

    // R7
    pred_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pred) |=> (!res_valid && !bad_count && $stable(res_data) && $stable(res_tag)));

    // R8
    zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pred && shamt == '0) |=> (bad_count && !res_valid && $stable(res_data)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && !bad_count && $stable(res_data) && $stable(res_tag)));

endmodule

bind psa_unit psa_unit_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .pred      (pred),
    .shamt     (shamt),
    .tag_a     (tag_a),
    .tag_b     (tag_b),
    .res_data  (res_data),
    .res_tag   (res_tag),
    .res_valid (res_valid),
    .bad_count (bad_count)
);

// File: tb/psa_unit_tb_top.sv
`timescale 1ns/1ps
module psa_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        pred = 1'b0;
    logic [1:0]  shamt = 2'd0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        tag_a = 1'b0;
    logic        tag_b = 1'b0;
    logic [63:0] res_data;
    logic        res_tag;
    logic        res_valid;
    logic        bad_count;

    int checks = 0;
    int fails  = 0;
    logic [63:0] held;

    always #4 clk = ~clk;

    psa_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .pred      (pred),
        .shamt     (shamt),
        .src_a     (src_a),
        .src_b     (src_b),
        .tag_a     (tag_a),
        .tag_b     (tag_b),
        .res_data  (res_data),
        .res_tag   (res_tag),
        .res_valid (res_valid),
        .bad_count (bad_count)
    );

    typedef struct packed {
        logic [63:0] a;
        logic [63:0] b;
        logic [1:0]  cnt;
        logic        ta;
        logic        tb;
        logic [63:0] exp;
        logic        exp_tag;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        // R1 R2: unsaturated lanes, mixed signs, count 1
        '{64'h1000_FFFF_0002_0001, 64'h0000_0001_FFFE_0003, 2'd1, 1'b0, 1'b0,
          64'h2000_FFFF_0002_0005, 1'b0},
        // R3 R4 R5: shift clamps (add skipped) next to exact limits, count 3
        '{64'h0FFF_EFFF_F000_1000, 64'h0007_7FFF_FFFF_8000, 2'd3, 1'b1, 1'b0,
          64'h7FFF_8000_8000_7FFF, 1'b1},
        // R5: add clamps both ways, count 2
        '{64'h0000_1FFF_F000_1000, 64'h8000_0003_9000_7000, 2'd2, 1'b0, 1'b1,
          64'h8000_7FFF_8000_7FFF, 1'b1},
        // R2 R4: zero fill, negative clamp skips add, count 2
        '{64'hC000_1234_FFFD_0003, 64'h7FFF_0001_0000_0000, 2'd2, 1'b1, 1'b1,
          64'h8000_48D1_FFF4_000C, 1'b1},
        // R3: lane 0 clamps on shift, add of -32768 skipped; count 1
        '{64'hBFFF_C000_3FFF_4000, 64'h7FFF_0000_0001_8000, 2'd1, 1'b0, 1'b0,
          64'h8000_8000_7FFF_7FFF, 1'b0}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic v, input logic p, input logic [1:0] c,
                         input logic [63:0] a, input logic [63:0] b,
                         input logic ta, input logic tb);
        @(negedge clk);
        req_valid = v; pred = p; shamt = c;
        src_a = a; src_b = b; tag_a = ta; tag_b = tb;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 data", res_data, 64'h0);
        check("R10 flags", {61'h0, res_tag, res_valid, bad_count}, 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            issue(1'b1, 1'b1, VECS[i].cnt, VECS[i].a, VECS[i].b, VECS[i].ta, VECS[i].tb);
            check("R1-lanes/R2..R5 data", res_data, VECS[i].exp);
            check("R6 tag", {63'h0, res_tag}, {63'h0, VECS[i].exp_tag});
            check("R9 valid", {62'h0, res_valid, bad_count}, 64'h2);
        end

        held = res_data;
        // R11: idle cycle holds result and drops valid
        @(negedge clk);
        check("R11 data held", res_data, held);
        check("R11 flags", {62'h0, res_valid, bad_count}, 64'h0);

        // R7: predicate false, different operands and tags
        issue(1'b1, 1'b0, 2'd1, 64'h0001_0001_0001_0001, 64'h0001_0001_0001_0001, 1'b1, 1'b1);
        check("R7 data held", res_data, held);
        check("R7 tag held", {63'h0, res_tag}, 64'h0);
        check("R7 flags", {62'h0, res_valid, bad_count}, 64'h0);

        // R7: predicate false with count 0 raises nothing
        issue(1'b1, 1'b0, 2'd0, 64'h0, 64'h0, 1'b0, 1'b0);
        check("R7 no fault", {62'h0, res_valid, bad_count}, 64'h0);

        // R8: illegal count
        issue(1'b1, 1'b1, 2'd0, 64'h0002_0002_0002_0002, 64'h0, 1'b1, 1'b0);
        check("R8 flags", {62'h0, res_valid, bad_count}, 64'h1);
        check("R8 data held", res_data, held);
        check("R8 tag held", {63'h0, res_tag}, 64'h0);
        @(negedge clk);
        check("R8 flag drops", {62'h0, res_valid, bad_count}, 64'h0);

        // R9: back-to-back legal requests, each one cycle later
        @(negedge clk);
        req_valid = 1'b1; pred = 1'b1; shamt = 2'd1;
        src_a = 64'h0000_0000_0000_0001; src_b = 64'h0; tag_a = 1'b0; tag_b = 1'b0;
        @(negedge clk);
        check("R9 first", res_data, 64'h0000_0000_0000_0002);
        src_a = 64'h0000_0000_0000_0003; shamt = 2'd3;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 second", res_data, 64'h0000_0000_0000_0018);
        check("R9 valid", {62'h0, res_valid, bad_count}, 64'h2);

        // R1: only lane 2 nonzero, lands in bits 47:32
        issue(1'b1, 1'b1, 2'd2, 64'h0000_0005_0000_0000, 64'h0000_0001_0000_0000, 1'b0, 1'b0);
        check("R1 lane placement", res_data, 64'h0000_0015_0000_0000);

        // R10: asynchronous reset clears held result
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        check("R10 reset again", {res_data[62:0], res_tag}, 64'h0);
        rst_n = 1'b1;

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule